// File: doc/BRIEF.md
# Mailbox Interrupt Prioritizer

This block sits beside a message controller with a bank of transmit mailboxes. Each mailbox reports the end of a transmission with a one-cycle event pulse. The block latches that pulse into a pending flag. It then qualifies the flag with a per-mailbox mask bit and steers it to one of two interrupt request lines according to a per-mailbox line-select bit.

Each line has its own global enable and its own vector output. The vector carries the index of the highest-priority qualifying mailbox, and the mailbox with the larger index wins. An "active" bit is set beside the vector whenever anything is pending on that line.

Software programs the masks, line selects and enables through a word-wide write port. It acknowledges events by writing ones to a clear register. While qualifying flags remain pending, the request line stays high. Clearing the serviced flag therefore leads straight to the next one, and no event is lost.

Top module: `mbx_irq_prio`

## Requirements
- R1: A one-cycle pulse on `evt_set[i]` sets pending flag i. The flag is visible on `pending_o[i]` from the clock edge that samples the pulse, and it stays set until it is cleared.
- R2: A write to address 3 clears every flag whose `wr_data` bit is 1 and leaves flags whose bit is 0 unchanged. If a set pulse and a clear of the same flag happen in the same cycle, the flag ends up set.
- R3: A flag whose mask bit is 0 does not drive either line's vector, active bit or request. The flag itself stays pending. If the mask bit is later set, the flag then raises the request.
- R4: A flag whose line-select bit is 1 qualifies only for line 1. A flag whose line-select bit is 0 qualifies only for line 0.
- R5: Bit 0 of the enable register gates `irq_o[0]` and bit 1 gates `irq_o[1]`. A line whose enable bit is 0 never asserts its request.
- R6: For each line, the vector equals the highest index among that line's qualifying pending flags, and the active bit is 1. When no flag qualifies, the vector is 0 and the active bit is 0. Both follow the flags with no added register stage.
- R7: `irq_o[l]` is registered. It is high exactly one cycle after a cycle in which line l is enabled and has at least one qualifying flag.
- R8: While other qualifying flags remain after the top one is cleared, the request stays high without a gap, and the vector moves to the next-highest pending index.
- R9: An asynchronous low level on `rst_n` clears all flags, masks, line selects, enables and requests.
- R10: Address 0 writes the mask bits, address 1 writes the line-select bits and address 2 writes the two enable bits. Each write loads the whole word at once, and bit i of the word belongs to mailbox i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_set | input | N_MBOX | One-cycle event pulses, one per mailbox |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mask, 1 line select, 2 enables, 3 clear flags) |
| wr_data | input | REG_W | Write data word |
| pending_o | output | N_MBOX | Pending event flags |
| irq_o | output | 2 | Registered request per line |
| act_o | output | 2 | Line has a qualifying flag |
| vec0_o | output | IDX_W | Highest qualifying index on line 0 |
| vec1_o | output | IDX_W | Highest qualifying index on line 1 |

## Verification
The bench builds the block with `N_MBOX = 8` and keeps the 32-bit write word. This makes it practical to sweep all 256 flag patterns under four combinations of mask, line select and enable, with the expected vectors and requests recomputed arithmetically for every pattern. At that size, directed sequences also reach the set-versus-clear collision, the drain of a stack of pending flags one at a time, late unmasking and reset with flags pending. Upper write bits beyond the mailbox count are exercised through all-ones clear words.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int NUM_LINES = 2;
  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_LSEL = 2'd1,
    ADDR_LEN  = 2'd2,
    ADDR_FCLR = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/mbx_cfg_regs.sv
module mbx_cfg_regs
  import mbx_irq_pkg::*;
#(
  parameter int N_MBOX = 32,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [N_MBOX-1:0] mask_q,
  output logic [N_MBOX-1:0] sel_q,
  output logic [NUM_LINES-1:0] en_q
);
  logic [N_MBOX-1:0]    mask_d, sel_d;
  logic [NUM_LINES-1:0] en_d;
  logic mask_we, sel_we, en_we;

  assign mask_we = wr_en && (wr_addr == ADDR_MASK);
  assign sel_we  = wr_en && (wr_addr == ADDR_LSEL);
  assign en_we   = wr_en && (wr_addr == ADDR_LEN);

  always_comb begin
    mask_d = mask_q;
    sel_d  = sel_q;
    en_d   = en_q;
    if (mask_we) mask_d = wr_data[N_MBOX-1:0];
    if (sel_we)  sel_d  = wr_data[N_MBOX-1:0];
    if (en_we)   en_d   = wr_data[NUM_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      sel_q  <= '0;
      en_q   <= '0;
    end else begin
      mask_q <= mask_d;
      sel_q  <= sel_d;
      en_q   <= en_d;
    end
  end
endmodule

// File: rtl/mbx_flag_store.sv
module mbx_flag_store #(
  parameter int N_MBOX = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] set_i,
  input  logic              clr_en,
  input  logic [N_MBOX-1:0] clr_bits,
  output logic [N_MBOX-1:0] flags_q
);
  logic [N_MBOX-1:0] clr_vec, flags_d;

  assign clr_vec = clr_en ? clr_bits : '0;

  always_comb begin
    flags_d = (flags_q & ~clr_vec) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/mbx_prio_enc.sv
module mbx_prio_enc #(
  parameter int N_MBOX = 32,
  parameter int IDX_W  = $clog2(N_MBOX)
) (
  input  logic [N_MBOX-1:0] req_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < N_MBOX; i++) begin
      if (req_i[i]) begin
        idx_o = i[IDX_W-1:0];
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mbx_irq_prio.sv
module mbx_irq_prio
  import mbx_irq_pkg::*;
#(
  parameter int N_MBOX = 32,
  parameter int REG_W  = 32,
  localparam int IDX_W = $clog2(N_MBOX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MBOX-1:0] evt_set,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [N_MBOX-1:0] pending_o,
  output logic [1:0]        irq_o,
  output logic [1:0]        act_o,
  output logic [IDX_W-1:0]  vec0_o,
  output logic [IDX_W-1:0]  vec1_o
);
  logic [N_MBOX-1:0]    flags_q, mask_q, sel_q;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] irq_d, irq_q, any_w;
  logic [IDX_W-1:0]     vec_w [NUM_LINES];
  logic                 clr_en;
  logic                 unused_hi;

  assign unused_hi = ^wr_data;
  assign clr_en    = wr_en && (wr_addr == ADDR_FCLR);

  mbx_cfg_regs #(.N_MBOX(N_MBOX), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mask_q(mask_q), .sel_q(sel_q), .en_q(en_q)
  );

  mbx_flag_store #(.N_MBOX(N_MBOX)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_en(clr_en),
    .clr_bits(wr_data[N_MBOX-1:0]), .flags_q(flags_q)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    logic [N_MBOX-1:0] qual;
    assign qual = flags_q & mask_q & ((l == 1) ? sel_q : ~sel_q);
    mbx_prio_enc #(.N_MBOX(N_MBOX), .IDX_W(IDX_W)) u_enc (
      .req_i(qual), .idx_o(vec_w[l]), .any_o(any_w[l])
    );
    assign irq_d[l] = en_q[l] & any_w[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign pending_o = flags_q;
  assign irq_o     = irq_q;
  assign act_o     = any_w;
  assign vec0_o    = vec_w[0];
  assign vec1_o    = vec_w[1];
endmodule

// File: rtl/mbx_irq_prio_chk.sv
module mbx_irq_prio_chk #(
  parameter int N_MBOX = 32,
  parameter int REG_W  = 32,
  localparam int IDX_W = $clog2(N_MBOX)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_MBOX-1:0] evt_set,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [REG_W-1:0]  wr_data,
  input logic [N_MBOX-1:0] flags,
  input logic [N_MBOX-1:0] mask,
  input logic [N_MBOX-1:0] sel,
  input logic [1:0]        en,
  input logic [1:0]        irq,
  input logic [1:0]        act,
  input logic [IDX_W-1:0]  vec0,
  input logic [IDX_W-1:0]  vec1
);
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((flags & $past(evt_set)) == $past(evt_set))); // R1
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ((flags & $past(wr_data[N_MBOX-1:0] & ~evt_set)) == '0)); // R2
  AST_LINE0_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en[0] |=> !irq[0]); // R5
  AST_LINE1_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en[1] |=> !irq[1]); // R5
  AST_IDLE_VEC0: assert property (@(posedge clk) disable iff (!rst_n)
    !act[0] |-> (vec0 == '0)); // R6
  AST_IDLE_VEC1: assert property (@(posedge clk) disable iff (!rst_n)
    !act[1] |-> (vec1 == '0)); // R6
  AST_VEC0_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    act[0] |-> (flags[vec0] && mask[vec0] && !sel[vec0])); // R3
  AST_VEC1_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    act[1] |-> (flags[vec1] && mask[vec1] && sel[vec1])); // R4
  AST_IRQ0_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq[0] == $past(en[0] && act[0]))); // R7
  AST_IRQ1_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq[1] == $past(en[1] && act[1]))); // R7
endmodule

bind mbx_irq_prio mbx_irq_prio_chk #(.N_MBOX(N_MBOX), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .flags(flags_q), .mask(mask_q),
  .sel(sel_q), .en(en_q), .irq(irq_o), .act(act_o), .vec0(vec0_o), .vec1(vec1_o)
);

// File: tb/mbx_irq_prio_test.sv
module mbx_irq_prio_test;
  localparam int N  = 8;
  localparam int RW = 32;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] evt_set;
  logic wr_en;
  logic [1:0] wr_addr;
  logic [RW-1:0] wr_data;
  logic [N-1:0] pending_o;
  logic [1:0] irq_o, act_o;
  logic [IW-1:0] vec0_o, vec1_o;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mbx_irq_prio #(.N_MBOX(N), .REG_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pending_o(pending_o),
    .irq_o(irq_o), .act_o(act_o), .vec0_o(vec0_o), .vec1_o(vec1_o)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [RW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int top_of(logic [N-1:0] q);
    for (int i = N - 1; i >= 0; i--) if (q[i]) return i;
    return 0;
  endfunction

  task automatic check_lines(string req, logic [N-1:0] fl, logic [N-1:0] m, logic [N-1:0] s);
    logic [N-1:0] q0, q1;
    q0 = fl & m & ~s;
    q1 = fl & m & s;
    chk({req, " act"}, 32'(act_o), 32'({|q1, |q0}));
    chk({req, " vec0"}, 32'(vec0_o), 32'(top_of(q0)));
    chk({req, " vec1"}, 32'(vec1_o), 32'(top_of(q1)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] mk [4];
    logic [N-1:0] sl [4];
    logic [1:0]   ek [4];
    mk[0] = 8'hFF; sl[0] = 8'h00; ek[0] = 2'b11;
    mk[1] = 8'hA5; sl[1] = 8'hF0; ek[1] = 2'b11;
    mk[2] = 8'hFF; sl[2] = 8'h5A; ek[2] = 2'b01;
    mk[3] = 8'h3C; sl[3] = 8'hFF; ek[3] = 2'b10;
    rst_n = 1'b0; evt_set = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 pending", 32'(pending_o), 0);
    chk("R9 irq", 32'(irq_o), 0);
    chk("R9 act", 32'(act_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep: R1 R3 R4 R5 R6 R7 R10, clear via R2
    for (int c = 0; c < 4; c++) begin
      wr(2'd0, RW'(mk[c]));
      wr(2'd1, RW'(sl[c]));
      wr(2'd2, RW'(ek[c]));
      for (int p = 0; p < 256; p++) begin
        logic [N-1:0] pat;
        logic [N-1:0] q0, q1;
        pat = p[N-1:0];
        q0 = pat & mk[c] & ~sl[c];
        q1 = pat & mk[c] & sl[c];
        evt_set = pat;
        @(negedge clk);
        evt_set = '0;
        chk("R1 pending", 32'(pending_o), 32'(pat));
        check_lines("R6/R3/R4/R10", pat, mk[c], sl[c]);
        @(negedge clk);
        chk("R7/R5 irq", 32'(irq_o), 32'({ek[c][1] & |q1, ek[c][0] & |q0}));
        wr(2'd3, '1);
        chk("R2 cleared", 32'(pending_o), 0);
      end
    end
    @(negedge clk);

    // R2: write of zeros leaves flags, set beats clear
    wr(2'd0, 32'hFF); wr(2'd1, 32'h00); wr(2'd2, 32'h1);
    evt_set = 8'h24; @(negedge clk); evt_set = '0;
    wr(2'd3, 32'h0);
    chk("R2 zero write", 32'(pending_o), 32'h24);
    evt_set = 8'h04;
    wr(2'd3, 32'hFF);
    evt_set = '0;
    chk("R2 set wins", 32'(pending_o), 32'h04);
    wr(2'd3, 32'hFF);

    // R8: drain stacked flags on line 0 without a gap
    evt_set = 8'h52; @(negedge clk); evt_set = '0;
    @(negedge clk);
    chk("R8 irq up", 32'(irq_o), 1);
    chk("R8 vec top", 32'(vec0_o), 6);
    wr(2'd3, 32'h40);
    chk("R8 vec next", 32'(vec0_o), 4);
    chk("R8 irq held", 32'(irq_o), 1);
    @(negedge clk);
    chk("R8 irq held2", 32'(irq_o), 1);
    wr(2'd3, 32'h10);
    chk("R8 vec last", 32'(vec0_o), 1);
    @(negedge clk);
    chk("R8 irq held3", 32'(irq_o), 1);
    wr(2'd3, 32'h02);
    chk("R8 act off", 32'(act_o), 0);
    @(negedge clk);
    chk("R8 irq off", 32'(irq_o), 0);

    // R3: masked flag stays pending, raises irq once unmasked
    wr(2'd0, 32'h00);
    evt_set = 8'h08; @(negedge clk); evt_set = '0;
    @(negedge clk);
    chk("R3 masked irq", 32'(irq_o), 0);
    chk("R3 still pending", 32'(pending_o), 32'h08);
    wr(2'd0, 32'h08);
    chk("R3 vec after unmask", 32'(vec0_o), 3);
    @(negedge clk);
    chk("R3 irq after unmask", 32'(irq_o), 1);

    // R9: asynchronous reset with state present
    #2 rst_n = 1'b0;
    #1;
    chk("R9 async pending", 32'(pending_o), 0);
    chk("R9 async irq", 32'(irq_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    evt_set = 8'h80; @(negedge clk); evt_set = '0;
    chk("R9 mask cleared", 32'(act_o), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule